// File: doc/BRIEF.md
# PCI Configuration Cycle Address Generator

This block turns a processor access to a sparse configuration window into one PCI configuration transaction. The processor address carries the target bus, device, function, register offset and a transfer-size code. From these fields the block picks the Type 0 or Type 1 address form and builds the 32-bit configuration address. It also forms the byte enables and moves write data onto the byte lanes named by the low offset bits. Read data comes back through the reverse shift.

The PCI side uses a simple request/acknowledge handshake. Bus-level signalling belongs to the master behind that handshake. Only one transaction is in flight at a time. A master abort reported with the acknowledge returns all-ones data and raises the error flag. A Type 1 access is only issued while a two-bit mode field reads 01; any other mode turns such an access into a local error. Malformed addresses are also answered locally with an error, and no bus cycle is started for them.

Top module: `pcfg_cycle_gen`

## Requirements
- R1: The processor address `cpu_addr[28:0]` is decoded as follows:
  - bus in bits 28:21
  - device in bits 20:16
  - function in bits 15:13
  - register offset in bits 12:5
  - size code in bits 4:3, where 00 is a byte, 01 is a 16-bit word and 11 is a 32-bit dword
  - bits 2:0 must be zero
- R2: When the bus is nonzero and `cfg_mode` is 01, `pci_type1` is 1 and `pci_addr` is {8'h00, bus, device, function, offset[7:2], 2'b01}.
- R3: When the bus is zero, `pci_type1` is 0. `pci_addr` then has a single 1 at bit 11+device for devices 0 to 20, and no select bit for devices 21 to 31. The function sits in bits 10:8, offset[7:2] in bits 7:2, and bits 1:0 are 00.
- R4: A nonzero bus while `cfg_mode` is not 01 starts no PCI request. The access completes with `cpu_err`=1 and `cpu_rdata`=32'hFFFF_FFFF.
- R5: Size code 10, or nonzero `cpu_addr[2:0]`, is handled the same way as R4: no PCI request, and an error completion with all-ones data.
- R6: The lane is offset[1:0]. `pci_be` is 0001<<lane for a byte, 0011<<lane for a word (truncated to 4 bits), and 1111 for a dword.
- R7: `pci_wdata` is `cpu_wdata` shifted left by 8×lane, and `pci_we` follows `cpu_we`.
- R8: On a completion without abort, `cpu_rdata` is `pci_rdata` shifted right by 8×lane, and `cpu_err` is 0.
- R9: When `pci_mabort` is high with `pci_ack`, the completion gives `cpu_rdata`=32'hFFFF_FFFF and `cpu_err`=1, for both reads and writes.
- R10: `cpu_busy` is high from the edge that accepts a request until the cycle after `cpu_done`. A `cpu_req` seen while busy is ignored.
- R11: `pci_req` is raised one cycle after acceptance. `pci_addr`, `pci_be`, `pci_wdata` and `pci_we` hold steady until the cycle in which `pci_ack` is sampled, and `pci_req` falls after that edge.
- R12: `cpu_done` is a one-cycle pulse in the cycle after `pci_ack` is sampled, or in the cycle after acceptance for a local error.
- R13: After reset, `cpu_busy`, `pci_req`, `cpu_done` and `cpu_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Mode field; 01 enables Type 1 cycles |
| cpu_req | input | 1 | Processor access strobe |
| cpu_we | input | 1 | 1 = configuration write |
| cpu_addr | input | 29 | Sparse configuration address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_busy | output | 1 | Transaction in progress |
| cpu_done | output | 1 | Completion pulse |
| cpu_err | output | 1 | Completion error, valid with cpu_done |
| cpu_rdata | output | 32 | Read data, right-aligned |
| pci_req | output | 1 | Configuration request to the PCI master |
| pci_type1 | output | 1 | 1 = Type 1 cycle |
| pci_we | output | 1 | 1 = configuration write |
| pci_addr | output | 32 | Configuration address |
| pci_be | output | 4 | Active-high byte enables |
| pci_wdata | output | 32 | Lane-aligned write data |
| pci_ack | input | 1 | Master has finished the cycle |
| pci_mabort | input | 1 | Cycle ended in master abort (with pci_ack) |
| pci_rdata | input | 32 | Lane-aligned read data (with pci_ack) |

## Verification
The directed tests cover several corners, each of which exposes a specific design fault:
- Devices 20 and 21 sit on the edge of the one-hot select range. A design with an off-by-one select would drive a stray bit 31, or drop device 20.
- Byte and word accesses at every lane catch a lane shift in the wrong direction, which would put data and enables on the wrong bytes.
- A Type 1 access with the mode field cleared, and a reserved size code, must never reach the bus. A lax design would raise `pci_req` for them.
- Master aborts on a read and on a write must force all-ones data. A design that passed the returned data through would leak bus garbage.
- A request asserted while a cycle is pending must neither disturb the held address nor start a second cycle.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int BUS_W    = 8;
  localparam int DEV_W    = 5;
  localparam int FN_W     = 3;
  localparam int OFF_W    = 8;
  localparam int SZ_W     = 2;
  localparam int PAD_W    = 3;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int LANE_W   = $clog2(LANES);
  localparam int SZ_LSB   = PAD_W;
  localparam int OFF_LSB  = SZ_LSB + SZ_W;
  localparam int FN_LSB   = OFF_LSB + OFF_W;
  localparam int DEV_LSB  = FN_LSB + FN_W;
  localparam int BUS_LSB  = DEV_LSB + DEV_W;
  localparam int CPU_AW   = BUS_LSB + BUS_W;
  localparam int SEL_LO   = FN_W + OFF_W;
  localparam int SEL_N    = DATA_W - SEL_LO;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_RSVD  = 2'b10,
    SZ_DWORD = 2'b11
  } size_e;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [OFF_W-1:0] off;
    size_e            size;
    logic [PAD_W-1:0] pad;
  } cfg_fields_t;

  function automatic cfg_fields_t f_split(input logic [CPU_AW-1:0] a);
    return cfg_fields_t'(a);
  endfunction

  function automatic logic [LANES-1:0] f_byte_en(input size_e sz,
                                                 input logic [LANE_W-1:0] lane);
    case (sz)
      SZ_BYTE: return LANES'(1) << lane;
      SZ_WORD: return LANES'(3) << lane;
      default: return '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] f_type1_addr(input logic [BUS_W-1:0] bus,
                                                     input logic [DEV_W-1:0] dev,
                                                     input logic [FN_W-1:0]  fn,
                                                     input logic [OFF_W-1:0] off);
    return {{(DATA_W-BUS_W-DEV_W-SEL_LO){1'b0}}, bus, dev, fn, off[OFF_W-1:2], 2'b01};
  endfunction

  function automatic logic [DATA_W-1:0] f_lane_up(input logic [DATA_W-1:0] d,
                                                  input logic [LANE_W-1:0] lane);
    return d << {lane, 3'b000};
  endfunction

  function automatic logic [DATA_W-1:0] f_lane_down(input logic [DATA_W-1:0] d,
                                                    input logic [LANE_W-1:0] lane);
    return d >> {lane, 3'b000};
  endfunction
endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode
  import pcfg_pkg::*;
(
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [1:0]        cfg_mode,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] dec_addr,
  output logic [LANES-1:0]  dec_be,
  output logic [DATA_W-1:0] dec_wdata,
  output logic [LANE_W-1:0] dec_lane,
  output logic              dec_type1,
  output logic              dec_reject
);
  cfg_fields_t       f;
  logic [SEL_N-1:0]  idsel;
  logic              bad_form;
  logic              bad_mode;

  assign f = f_split(cpu_addr);

  for (genvar g = 0; g < SEL_N; g++) begin : g_idsel
    assign idsel[g] = (f.dev == DEV_W'(g));
  end

  assign dec_lane  = f.off[LANE_W-1:0];
  assign dec_type1 = (f.bus != '0);
  assign bad_form  = (f.size == SZ_RSVD) || (f.pad != '0);
  assign bad_mode  = dec_type1 && (cfg_mode != 2'b01);
  assign dec_reject = bad_form || bad_mode;

  always_comb begin
    if (dec_type1) dec_addr = f_type1_addr(f.bus, f.dev, f.fn, f.off);
    else           dec_addr = {idsel, f.fn, f.off[OFF_W-1:2], 2'b00};
  end

  assign dec_be    = f_byte_en(f.size, dec_lane);
  assign dec_wdata = f_lane_up(cpu_wdata, dec_lane);
endmodule

// File: rtl/pcfg_lanes.sv
module pcfg_lanes
  import pcfg_pkg::*;
(
  input  logic [DATA_W-1:0] pci_rdata,
  input  logic [LANE_W-1:0] lane,
  input  logic              mabort,
  output logic [DATA_W-1:0] rsp_data
);
  assign rsp_data = mabort ? '1 : f_lane_down(pci_rdata, lane);
endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] dec_addr,
  input  logic [LANES-1:0]  dec_be,
  input  logic [DATA_W-1:0] dec_wdata,
  input  logic [LANE_W-1:0] dec_lane,
  input  logic              dec_type1,
  input  logic              dec_reject,
  input  logic              pci_ack,
  input  logic              pci_mabort,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [LANE_W-1:0] lane_q,
  output logic              busy,
  output logic              done_q,
  output logic              err_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              pci_req_q,
  output logic              type1_q,
  output logic              we_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              accept_evt,
  output logic              finish_evt
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RESP} state_e;
  state_e state;

  assign busy       = (state != S_IDLE);
  assign accept_evt = (state == S_IDLE) && cpu_req;
  assign finish_evt = (state == S_ISSUE) && pci_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
      pci_req_q <= 1'b0;
      type1_q   <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      lane_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept_evt) begin
            if (dec_reject) begin
              state   <= S_RESP;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '1;
            end else begin
              state     <= S_ISSUE;
              pci_req_q <= 1'b1;
              type1_q   <= dec_type1;
              we_q      <= cpu_we;
              addr_q    <= dec_addr;
              be_q      <= dec_be;
              wdata_q   <= dec_wdata;
              lane_q    <= dec_lane;
            end
          end
        end
        S_ISSUE: begin
          if (finish_evt) begin
            state     <= S_RESP;
            pci_req_q <= 1'b0;
            done_q    <= 1'b1;
            err_q     <= pci_mabort;
            rdata_q   <= rsp_data;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcfg_cycle_gen.sv
module pcfg_cycle_gen
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic              cpu_err,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              pci_req,
  output logic              pci_type1,
  output logic              pci_we,
  output logic [DATA_W-1:0] pci_addr,
  output logic [LANES-1:0]  pci_be,
  output logic [DATA_W-1:0] pci_wdata,
  input  logic              pci_ack,
  input  logic              pci_mabort,
  input  logic [DATA_W-1:0] pci_rdata
);
  logic [DATA_W-1:0] dec_addr, dec_wdata, rsp_data;
  logic [LANES-1:0]  dec_be;
  logic [LANE_W-1:0] dec_lane, lane_q;
  logic              dec_type1, dec_reject;
  logic              accept_evt, finish_evt;

  pcfg_decode u_decode (
    .cpu_addr  (cpu_addr),
    .cfg_mode  (cfg_mode),
    .cpu_wdata (cpu_wdata),
    .dec_addr  (dec_addr),
    .dec_be    (dec_be),
    .dec_wdata (dec_wdata),
    .dec_lane  (dec_lane),
    .dec_type1 (dec_type1),
    .dec_reject(dec_reject)
  );

  pcfg_lanes u_lanes (
    .pci_rdata(pci_rdata),
    .lane     (lane_q),
    .mabort   (pci_mabort),
    .rsp_data (rsp_data)
  );

  pcfg_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .dec_addr  (dec_addr),
    .dec_be    (dec_be),
    .dec_wdata (dec_wdata),
    .dec_lane  (dec_lane),
    .dec_type1 (dec_type1),
    .dec_reject(dec_reject),
    .pci_ack   (pci_ack),
    .pci_mabort(pci_mabort),
    .rsp_data  (rsp_data),
    .lane_q    (lane_q),
    .busy      (cpu_busy),
    .done_q    (cpu_done),
    .err_q     (cpu_err),
    .rdata_q   (cpu_rdata),
    .pci_req_q (pci_req),
    .type1_q   (pci_type1),
    .we_q      (pci_we),
    .addr_q    (pci_addr),
    .be_q      (pci_be),
    .wdata_q   (pci_wdata),
    .accept_evt(accept_evt),
    .finish_evt(finish_evt)
  );
endmodule

// File: rtl/pcfg_cycle_gen_chk.sv
module pcfg_cycle_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_busy,
  input logic        cpu_done,
  input logic        cpu_err,
  input logic [31:0] cpu_rdata,
  input logic        pci_req,
  input logic        pci_type1,
  input logic [31:0] pci_addr,
  input logic [3:0]  pci_be,
  input logic        pci_ack,
  input logic        accept_evt,
  input logic        finish_evt
);
  a_r2_type1_shape: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && pci_type1 |-> pci_addr[1:0] == 2'b01 && pci_addr[31:24] == 8'h00);

  a_r3_type0_shape: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && !pci_type1 |-> pci_addr[1:0] == 2'b00 && $onehot0(pci_addr[31:11]));

  a_r6_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req |-> pci_be != 4'b0000);

  a_r9_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_err |-> cpu_rdata == 32'hFFFF_FFFF);

  a_r10_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req || cpu_done) |-> cpu_busy);

  a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && !pci_ack |=> pci_req && $stable(pci_addr) && $stable(pci_be));

  a_r11_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> !pci_req && cpu_done);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> !cpu_busy);
endmodule

bind pcfg_cycle_gen pcfg_cycle_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_busy  (cpu_busy),
  .cpu_done  (cpu_done),
  .cpu_err   (cpu_err),
  .cpu_rdata (cpu_rdata),
  .pci_req   (pci_req),
  .pci_type1 (pci_type1),
  .pci_addr  (pci_addr),
  .pci_be    (pci_be),
  .pci_ack   (pci_ack),
  .accept_evt(accept_evt),
  .finish_evt(finish_evt)
);

// File: tb/pcfg_cycle_gen_tb.sv
`timescale 1ns/1ps
module pcfg_cycle_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [28:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_busy, cpu_done, cpu_err;
  logic [31:0] cpu_rdata;
  logic        pci_req, pci_type1, pci_we;
  logic [31:0] pci_addr, pci_wdata;
  logic [3:0]  pci_be;
  logic        pci_ack = 1'b0;
  logic        pci_mabort = 1'b0;
  logic [31:0] pci_rdata = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pcfg_cycle_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .pci_req(pci_req), .pci_type1(pci_type1), .pci_we(pci_we), .pci_addr(pci_addr),
    .pci_be(pci_be), .pci_wdata(pci_wdata), .pci_ack(pci_ack),
    .pci_mabort(pci_mabort), .pci_rdata(pci_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [28:0] mk_addr(input logic [7:0] bus, input logic [4:0] dev,
                                          input logic [2:0] fn, input logic [7:0] off,
                                          input logic [1:0] sz);
    return {bus, dev, fn, off, sz, 3'b000};
  endfunction

  // Expected address from R2 and R3, built arithmetically.
  function automatic logic [31:0] exp_addr(input logic [7:0] bus, input logic [4:0] dev,
                                           input logic [2:0] fn, input logic [7:0] off);
    logic [31:0] a;
    a = (32'(fn) << 8) | (32'(off) & 32'h0000_00FC);
    if (bus != 0) a = a | (32'(bus) << 16) | (32'(dev) << 11) | 32'h1;
    else if (dev <= 5'd20) a = a | (32'h1 << (11 + int'(dev)));
    return a;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lane);
    int m;
    m = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 3 : 15;
    if (sz != 2'b11) m = m * (1 << lane);
    return 4'(m & 15);
  endfunction

  // Full transaction: request, check PCI side, acknowledge, check completion.
  task automatic t_cycle(input string tag, input logic [7:0] bus, input logic [4:0] dev,
                         input logic [2:0] fn, input logic [7:0] off, input logic [1:0] sz,
                         input logic we, input logic [31:0] wd, input logic [31:0] rsp,
                         input logic mab);
    logic [1:0] lane;
    lane = off[1:0];
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = mk_addr(bus, dev, fn, off, sz); cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(tag, "pci_req", 32'(pci_req), 32'd1);
    chk(tag, "pci_type1", 32'(pci_type1), 32'(bus != 0));
    chk(tag, "pci_addr", pci_addr, exp_addr(bus, dev, fn, off));
    chk(tag, "pci_be", 32'(pci_be), 32'(exp_be(sz, lane)));
    chk(tag, "pci_wdata R7", pci_wdata, wd << (8 * lane));
    chk(tag, "pci_we R7", 32'(pci_we), 32'(we));
    pci_ack = 1'b1; pci_mabort = mab; pci_rdata = rsp;
    @(negedge clk);
    pci_ack = 1'b0; pci_mabort = 1'b0; pci_rdata = '0;
    chk(tag, "cpu_done R12", 32'(cpu_done), 32'd1);
    chk(tag, "pci_req low R11", 32'(pci_req), 32'd0);
    chk(tag, "cpu_err", 32'(cpu_err), 32'(mab));
    chk(tag, "cpu_rdata", cpu_rdata, mab ? 32'hFFFF_FFFF : (rsp >> (8 * lane)));
    @(negedge clk);
    chk(tag, "done pulse R12", 32'(cpu_done), 32'd0);
  endtask

  // Locally rejected access: no PCI request, error completion.
  task automatic t_reject(input string tag, input logic [28:0] a);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(tag, "no pci_req", 32'(pci_req), 32'd0);
    chk(tag, "cpu_done", 32'(cpu_done), 32'd1);
    chk(tag, "cpu_err", 32'(cpu_err), 32'd1);
    chk(tag, "cpu_rdata", cpu_rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(tag, "still no pci_req", 32'(pci_req), 32'd0);
  endtask

  task automatic t_reset;
    chk("R13", "busy", 32'(cpu_busy), 32'd0);
    chk("R13", "pci_req", 32'(pci_req), 32'd0);
    chk("R13", "done", 32'(cpu_done), 32'd0);
    chk("R13", "err", 32'(cpu_err), 32'd0);
  endtask

  // R10/R11: second request while pending is ignored and address holds.
  task automatic t_busy;
    logic [31:0] first;
    first = exp_addr(8'd0, 5'd4, 3'd2, 8'h40);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk_addr(8'd0, 5'd4, 3'd2, 8'h40, 2'b11);
    @(negedge clk);
    chk("R10", "busy after accept", 32'(cpu_busy), 32'd1);
    cpu_addr = mk_addr(8'd0, 5'd9, 3'd5, 8'h10, 2'b00);
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R11", "pci_req held", 32'(pci_req), 32'd1);
    chk("R11", "addr held", pci_addr, first);
    pci_ack = 1'b1; pci_rdata = 32'hCAFE_0001;
    @(negedge clk);
    pci_ack = 1'b0;
    chk("R12", "done", 32'(cpu_done), 32'd1);
    chk("R10", "busy during done", 32'(cpu_busy), 32'd1);
    @(negedge clk);
    chk("R10", "busy cleared", 32'(cpu_busy), 32'd0);
    chk("R10", "no second cycle", 32'(pci_req), 32'd0);
    @(negedge clk);
    chk("R10", "still idle", 32'(pci_req), 32'd0);
  endtask

  initial begin
    #100000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_mode = 2'b01;
    t_cycle("R1 R3 R8 dword", 8'd0, 5'd3, 3'd1, 8'h10, 2'b11, 1'b0, 32'h0, 32'h1234_5678, 1'b0);
    t_cycle("R3 R6 R7 byte lane3", 8'd0, 5'd0, 3'd7, 8'h3F, 2'b00, 1'b1, 32'h0000_00A5, 32'h0, 1'b0);
    t_cycle("R6 R8 word lane2", 8'd0, 5'd12, 3'd0, 8'h0E, 2'b01, 1'b0, 32'h0, 32'hBEEF_0000, 1'b0);
    t_cycle("R8 byte lane1", 8'd0, 5'd1, 3'd0, 8'h01, 2'b00, 1'b0, 32'h0, 32'h0000_7700, 1'b0);
    t_cycle("R3 dev20", 8'd0, 5'd20, 3'd3, 8'h08, 2'b11, 1'b0, 32'h0, 32'h1, 1'b0);
    t_cycle("R3 dev21 noselect", 8'd0, 5'd21, 3'd0, 8'h00, 2'b11, 1'b0, 32'h0, 32'h2, 1'b0);
    t_cycle("R2 type1 read", 8'd5, 5'd31, 3'd6, 8'hFC, 2'b11, 1'b0, 32'h0, 32'h89AB_CDEF, 1'b0);
    t_cycle("R2 R7 type1 word write", 8'd200, 5'd2, 3'd1, 8'h06, 2'b01, 1'b1, 32'h0000_1234, 32'h0, 1'b0);
    t_cycle("R9 mabort read", 8'd0, 5'd7, 3'd0, 8'h02, 2'b00, 1'b0, 32'h0, 32'h1357_9BDF, 1'b1);
    t_cycle("R9 mabort write", 8'd1, 5'd0, 3'd0, 8'h04, 2'b11, 1'b1, 32'hFFFF_0000, 32'h0, 1'b1);
    cfg_mode = 2'b00;
    t_reject("R4 type1 mode off", mk_addr(8'd2, 5'd1, 3'd0, 8'h00, 2'b11));
    cfg_mode = 2'b11;
    t_reject("R4 type1 mode 11", mk_addr(8'd9, 5'd1, 3'd0, 8'h00, 2'b11));
    t_cycle("R4 type0 mode ignored", 8'd0, 5'd5, 3'd0, 8'h20, 2'b11, 1'b0, 32'h0, 32'h55AA_55AA, 1'b0);
    cfg_mode = 2'b01;
    t_reject("R5 reserved size", mk_addr(8'd0, 5'd1, 3'd0, 8'h00, 2'b10));
    t_reject("R5 low bits", mk_addr(8'd0, 5'd1, 3'd0, 8'h00, 2'b11) | 29'h4);
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule